// File: doc/BRIEF.md
# Brute-Force Key Search Array

This block is a rectangular array of identical search cells that work together to recover a small secret key. Each cell owns one candidate key, which it derives only from its row and column. A stream of plaintext/ciphertext chunks is broadcast to every cell at once. On every accepted chunk, each cell enciphers the plaintext under its own key with a fixed 4-bit toy cipher and compares the result with the ciphertext.

A cell keeps a sticky flag that says whether its key has agreed with every chunk seen since the last init. Cells whose flag is set offer their key to a chain of registered forwarding stages. Each stage takes results from its left and lower neighbours and hands one result to its upper and right neighbours. The collection point is the upper-right cell.

In use, the host pulses init and streams a few chunks. It then waits for the forwarding to settle and reads the winning key at the corner. A single chunk can match several keys. Later chunks remove the false candidates until one key is left.

Top module: `keysearch_grid`

## Requirements
- R1: The cell at row r (row 0 is the bottom) and column c (column 0 is the left) owns the key (COLS*r + c + 1) mod 16. With the default 4x4 array the 16 cells own all 16 keys, and key 0 (owned by the upper-right cell) is reported like any other key.
- R2: The cipher is C = S[P xor K] xor rotr1(K). Here rotr1 rotates the 4-bit key right by one place, and S is the table {C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2} indexed from 0.
- R3: A chunk is accepted only on a clock edge where chunk_valid_i and chunk_ready_o are both high. The block never stalls except during init: chunk_ready_o is low exactly in the cycles where init_i is high. A chunk presented without acceptance changes no cell state.
- R4: init_i clears every cell flag and every record of earlier mismatches. With no chunk after init, found_o reads 0 once the settle time of ROWS+COLS-1 cycles has passed.
- R5: A cell's flag is set only if its key matched every chunk accepted since the last init, and at least one chunk has been accepted. One mismatch clears the flag until the next init.
- R6: Each forwarding stage registers its output with this priority: its own key if its flag is set, otherwise the left neighbour's result if valid, otherwise the lower neighbour's result. The corner output is final ROWS+COLS-1 cycles after the last accepted chunk and holds steady afterwards.
- R7: A result carries a valid bit. When no key is being sent, found_o is 0 and found_key_o is 0. Both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Clears all cell flags; blocks chunk acceptance in the same cycle |
| chunk_valid_i | input | 1 | A plaintext/ciphertext chunk is offered |
| chunk_ready_o | output | 1 | The array can take a chunk this cycle |
| plain_i | input | 4 | Plaintext nibble of the chunk |
| cipher_i | input | 4 | Ciphertext nibble of the chunk |
| found_o | output | 1 | The corner holds a matching key |
| found_key_o | output | 4 | The key collected at the corner, 0 when none |

## Verification
The checker watches several behaviours on every cycle. It checks that an idle result carries a zero key and that reset leaves the corner empty. It checks that the corner goes empty once the settle window after an init passes with no chunk. It also checks that a settled corner holds steady, and that any settled key enciphers the last accepted plaintext to its ciphertext.

Some properties need a full chunk history, so only the bench scenarios can show them. These are the forwarding priority when several keys survive, the narrowing of an ambiguous match by later chunks, and the loss of every candidate when chunks contradict each other. The same goes for the cell that owns key 0 and for chunks that are offered but not accepted.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int KW = 4;

  typedef struct packed {
    logic          vld;
    logic [KW-1:0] key;
  } fwd_t;

  function automatic logic [KW-1:0] subst(input logic [KW-1:0] x);
    logic [KW-1:0] y;
    case (x)
      4'h0: y = 4'hC;  4'h1: y = 4'h5;  4'h2: y = 4'h6;  4'h3: y = 4'hB;
      4'h4: y = 4'h9;  4'h5: y = 4'h0;  4'h6: y = 4'hA;  4'h7: y = 4'hD;
      4'h8: y = 4'h3;  4'h9: y = 4'hE;  4'hA: y = 4'hF;  4'hB: y = 4'h8;
      4'hC: y = 4'h4;  4'hD: y = 4'h7;  4'hE: y = 4'h1;  default: y = 4'h2;
    endcase
    return y;
  endfunction

  function automatic logic [KW-1:0] encipher(input logic [KW-1:0] p,
                                             input logic [KW-1:0] k);
    return subst(p ^ k) ^ {k[0], k[KW-1:1]};
  endfunction
endpackage

// File: rtl/ks_cipher.sv
module ks_cipher
  import ks_pkg::*;
(
  input  logic [KW-1:0] key_i,
  input  logic [KW-1:0] plain_i,
  input  logic [KW-1:0] cipher_i,
  output logic          agree_o
);
  logic [KW-1:0] ct;

  always_comb begin
    ct      = encipher(plain_i, key_i);
    agree_o = (ct == cipher_i);
  end
endmodule

// File: rtl/ks_match.sv
module ks_match (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic take_i,
  input  logic agree_i,
  output logic flag_o
);
  logic failed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      failed <= 1'b0;
    end else if (init_i) begin
      flag_o <= 1'b0;
      failed <= 1'b0;
    end else if (take_i) begin
      if (agree_i && !failed) begin
        flag_o <= 1'b1;
      end else begin
        flag_o <= 1'b0;
        failed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ks_fwd.sv
module ks_fwd
  import ks_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          own_hit_i,
  input  logic [KW-1:0] own_key_i,
  input  fwd_t          left_i,
  input  fwd_t          below_i,
  output fwd_t          out_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            out_o <= '0;
    else if (own_hit_i)    out_o <= '{vld: 1'b1, key: own_key_i};
    else if (left_i.vld)   out_o <= left_i;
    else                   out_o <= below_i;
  end
endmodule

// File: rtl/ks_cell.sv
module ks_cell
  import ks_pkg::*;
#(
  parameter int ROW  = 0,
  parameter int COL  = 0,
  parameter int COLS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          take_i,
  input  logic [KW-1:0] plain_i,
  input  logic [KW-1:0] cipher_i,
  input  fwd_t          left_i,
  input  fwd_t          below_i,
  output fwd_t          out_o
);
  localparam int            KEY_IDX = (COLS * ROW + COL + 1) % (1 << KW);
  localparam logic [KW-1:0] OWN_KEY = KW'(KEY_IDX);

  logic agree;
  logic flag;

  ks_cipher u_ciph (
    .key_i    (OWN_KEY),
    .plain_i  (plain_i),
    .cipher_i (cipher_i),
    .agree_o  (agree)
  );

  ks_match u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .init_i  (init_i),
    .take_i  (take_i),
    .agree_i (agree),
    .flag_o  (flag)
  );

  ks_fwd u_fwd (
    .clk       (clk),
    .rst_n     (rst_n),
    .own_hit_i (flag),
    .own_key_i (OWN_KEY),
    .left_i    (left_i),
    .below_i   (below_i),
    .out_o     (out_o)
  );
endmodule

// File: rtl/keysearch_grid.sv
module keysearch_grid
  import ks_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          chunk_valid_i,
  output logic          chunk_ready_o,
  input  logic [KW-1:0] plain_i,
  input  logic [KW-1:0] cipher_i,
  output logic          found_o,
  output logic [KW-1:0] found_key_o
);
  localparam int TOP = ROWS - 1;
  localparam int RGT = COLS - 1;

  logic take;
  fwd_t res   [ROWS][COLS];
  fwd_t lft_w [ROWS][COLS];
  fwd_t blw_w [ROWS][COLS];

  assign chunk_ready_o = !init_i;
  assign take          = chunk_valid_i && chunk_ready_o;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      if (c == 0) begin : g_edge_l
        assign lft_w[r][c] = '0;
      end else begin : g_link_l
        assign lft_w[r][c] = res[r][c-1];
      end
      if (r == 0) begin : g_edge_b
        assign blw_w[r][c] = '0;
      end else begin : g_link_b
        assign blw_w[r][c] = res[r-1][c];
      end

      ks_cell #(.ROW(r), .COL(c), .COLS(COLS)) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (init_i),
        .take_i   (take),
        .plain_i  (plain_i),
        .cipher_i (cipher_i),
        .left_i   (lft_w[r][c]),
        .below_i  (blw_w[r][c]),
        .out_o    (res[r][c])
      );
    end
  end

  assign found_o     = res[TOP][RGT].vld;
  assign found_key_o = res[TOP][RGT].key;
endmodule

// File: rtl/ks_grid_chk.sv
module ks_grid_chk
  import ks_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init_i,
  input logic          chunk_valid_i,
  input logic          chunk_ready_o,
  input logic [KW-1:0] plain_i,
  input logic [KW-1:0] cipher_i,
  input logic          found_o,
  input logic [KW-1:0] found_key_o
);
  localparam int SETTLE = ROWS + COLS - 1;
  localparam int CW     = $clog2(SETTLE + 2) + 1;

  logic [CW-1:0] quiet;
  logic          last_init;
  logic [KW-1:0] last_p, last_c;
  logic          accepted;

  assign accepted = chunk_valid_i && chunk_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet     <= '0;
      last_init <= 1'b1;
      last_p    <= '0;
      last_c    <= '0;
    end else if (init_i) begin
      quiet     <= '0;
      last_init <= 1'b1;
    end else if (accepted) begin
      quiet     <= '0;
      last_init <= 1'b0;
      last_p    <= plain_i;
      last_c    <= cipher_i;
    end else if (quiet < CW'(SETTLE + 1)) begin
      quiet     <= quiet + 1'b1;
    end
  end

  // R7
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> (!found_o && found_key_o == '0));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !found_o |-> found_key_o == '0);

  // R4
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_init && quiet >= CW'(SETTLE)) |-> !found_o);

  // R6
  settled_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet >= CW'(SETTLE + 1)) |-> ($stable(found_o) && $stable(found_key_o)));

  // R2
  key_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet >= CW'(SETTLE) && !last_init && found_o)
      |-> encipher(last_p, found_key_o) == last_c);
endmodule

bind keysearch_grid ks_grid_chk #(.ROWS(ROWS), .COLS(COLS)) chk_i (.*);

// File: tb/keysearch_grid_tb_top.sv
module keysearch_grid_tb_top;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int WAIT = ROWS + COLS + 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_i = 1'b0;
  logic       chunk_valid_i = 1'b0;
  logic       chunk_ready_o;
  logic [3:0] plain_i = '0;
  logic [3:0] cipher_i = '0;
  logic       found_o;
  logic [3:0] found_key_o;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  logic [15:0] cand;
  bit          any_chunk;

  always #5 clk = ~clk;

  keysearch_grid #(.ROWS(ROWS), .COLS(COLS)) dut_i (.*);

  // R2 cipher, written from the requirement
  function automatic logic [3:0] sb(input logic [3:0] x);
    logic [3:0] t [16] = '{4'hC,4'h5,4'h6,4'hB,4'h9,4'h0,4'hA,4'hD,
                           4'h3,4'hE,4'hF,4'h8,4'h4,4'h7,4'h1,4'h2};
    return t[x];
  endfunction

  function automatic logic [3:0] enc(input logic [3:0] p, input logic [3:0] k);
    return sb(p ^ k) ^ {k[0], k[3:1]};
  endfunction

  // R1 / R6 expected corner result from surviving candidates
  function automatic logic [4:0] predict();
    logic [4:0] w [ROWS][COLS];
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        logic [3:0] kk;
        kk = 4'((COLS * r + c + 1) % 16);
        if (any_chunk && cand[kk])        w[r][c] = {1'b1, kk};
        else if (c > 0 && w[r][c-1][4])   w[r][c] = w[r][c-1];
        else if (r > 0)                   w[r][c] = w[r-1][c];
        else                              w[r][c] = '0;
      end
    end
    return w[ROWS-1][COLS-1];
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got found=%0b key=%0h, expected found=%0b key=%0h",
               req, act[4], act[3:0], exp[4], exp[3:0]);
    end
  endtask

  task automatic settle();
    repeat (WAIT) @(negedge clk);
  endtask

  task automatic do_init();
    @(negedge clk);
    init_i = 1'b1;
    @(negedge clk);
    init_i = 1'b0;
    cand = '1;
    any_chunk = 1'b0;
  endtask

  task automatic send(input logic [3:0] p, input logic [3:0] c);
    @(negedge clk);
    chunk_valid_i = 1'b1;
    plain_i  = p;
    cipher_i = c;
    @(negedge clk);
    chunk_valid_i = 1'b0;
    for (int k = 0; k < 16; k++)
      if (enc(p, 4'(k)) != c) cand[k] = 1'b0;
    any_chunk = 1'b1;
  endtask

  task automatic t_reset();
    check("R7 reset", {found_o, found_key_o}, 5'b0);
    check("R3 ready after reset", {4'b0, chunk_ready_o}, 5'b1);
  endtask

  task automatic t_secret(input logic [3:0] key, input logic [3:0] p0, input logic [3:0] p1);
    do_init();
    send(p0, enc(p0, key));
    send(p1, enc(p1, key));
    send(p0 ^ 4'h9, enc(p0 ^ 4'h9, key));
    settle();
    check("R1/R2/R6 secret key", {found_o, found_key_o}, predict());
  endtask

  task automatic t_ambiguous(input logic [3:0] key);
    logic [3:0] pick;
    pick = 4'h0;
    for (int p = 15; p >= 0; p--) begin
      int n;
      n = 0;
      for (int k = 0; k < 16; k++)
        if (enc(4'(p), 4'(k)) == enc(4'(p), key)) n++;
      if (n >= 2) pick = 4'(p);
    end
    do_init();
    send(pick, enc(pick, key));
    settle();
    check("R6 priority among several matches", {found_o, found_key_o}, predict());
    for (int p = 0; p < 16; p++) send(4'(p), enc(4'(p), key));
    settle();
    check("R5 later chunks narrow to the secret", {found_o, found_key_o}, {1'b1, key});
  endtask

  task automatic t_nomatch();
    do_init();
    send(4'h3, enc(4'h3, 4'h6));
    send(4'h3, enc(4'h3, 4'h6) ^ 4'h1);
    settle();
    check("R5 contradicting chunks leave no key", {found_o, found_key_o}, 5'b0);
  endtask

  task automatic t_init_clear();
    do_init();
    send(4'h5, enc(4'h5, 4'hB));
    send(4'hA, enc(4'hA, 4'hB));
    settle();
    check("R5 match before init", {found_o, found_key_o}, predict());
    do_init();
    settle();
    check("R4 init clears result", {found_o, found_key_o}, 5'b0);
  endtask

  task automatic t_ignore();
    do_init();
    @(negedge clk);
    plain_i  = 4'h2;
    cipher_i = enc(4'h2, 4'h4);
    chunk_valid_i = 1'b0;
    settle();
    check("R3 data without valid ignored", {found_o, found_key_o}, 5'b0);
    @(negedge clk);
    init_i = 1'b1;
    chunk_valid_i = 1'b1;
    #1;
    check("R3 ready low during init", {4'b0, chunk_ready_o}, 5'b0);
    @(negedge clk);
    init_i = 1'b0;
    chunk_valid_i = 1'b0;
    cand = '1;
    any_chunk = 1'b0;
    settle();
    check("R3 chunk during init ignored", {found_o, found_key_o}, 5'b0);
  endtask

  initial begin
    cand = '1;
    any_chunk = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 idle after reset release", {found_o, found_key_o}, 5'b0);
    t_secret(4'h0, 4'h1, 4'h7);   // R1 key 0 at the corner cell
    t_secret(4'h1, 4'h4, 4'hE);
    t_secret(4'h7, 4'hC, 4'h3);
    t_secret(4'hA, 4'h0, 4'h9);
    t_secret(4'hF, 4'h6, 4'hD);
    t_ambiguous(4'h5);
    t_ambiguous(4'hC);
    t_nomatch();
    t_init_clear();
    t_ignore();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule